// File: doc/BRIEF.md
# Card Command Response Capture

This block sits between a host's command register and a memory card's command channel. A write of a 16-bit command word, when the controller is enabled and idle, is decoded into an index, a response kind, a command class and a data direction. The block then issues a one-cycle card request carrying the index and a 32-bit argument. It collects the card's answer, which arrives as a byte count followed by a valid/ready byte stream.

When the answer is complete, the block checks the answer length against the response kind and screens the response for card error bits. It stores the bytes as eight 16-bit response words and updates a command status register. The interrupt line is driven from that status and a 15-bit enable mask. A command of the addressed-data class also arms the data transfer engine through a direction latch, an active flag and a one-cycle buffer reset.

Command word layout: bits 5:0 index, bit 7 init, bits 10:8 response kind (0 none, 1 short status, 2 long 16-byte, 3 operating-condition, 6 published address; other codes mean none), bit 11 busy, bits 13:12 command class (3 = addressed data), bit 15 direction. Status bits: 0 command done, 2 stop done, 7 timeout, 12 card busy, 14 response error.

Top module: `cmd_resp_capture`

## Requirements
- R1: An accepted command word gives exactly one cycle of `card_req_valid`, with `card_req_index` equal to word bits 5:0 and `card_req_arg` equal to `cmd_arg`.
- R2: A command write while `ctl_enable` is low, or while `busy` is high, is ignored: no request is issued, and status and response words keep their values.
- R3: An accepted command clears all eight response words in the cycle it is accepted.
- R4: An accepted command with init set and index 0 issues no request and only sets status bit 0.
- R5: Kinds 1, 3 and 6 need at least 4 answer bytes and kind 2 needs at least 16. Kind 1 with the busy bit set is handled the same way as kind 1. A shorter answer sets status bit 7 instead of bit 0, and the response words stay zero.
- R6: For kind 3, if bit 31 of the big-endian first four bytes is 0, status bit 12 is set.
- R7: Kind 1 ANDs the first four bytes, taken big-endian, with 0xFDF90000. Kind 6 ANDs bytes 2..3 with 0xE008. A nonzero result sets status bit 14. Every other completed command clears bit 14.
- R8: Answer byte 2j is the upper byte and byte 2j+1 the lower byte of response word 7-j. Response word k appears at `rsp_words[16k+15:16k]`.
- R9: A successful command with index 12 sets status bits 0 and 2. Any other index sets bit 0 only.
- R10: An accepted command of class 3 sets `xfer_active`, latches `xfer_dir` from bit 15 and pulses `buf_rst` for one cycle. Any other accepted command clears `xfer_active`.
- R11: A status write clears the bits written as 1. A bit set by the block in the same cycle wins over the clear.
- R12: `irq` is high when any status bit 14..0 is set together with the matching bit of the mask, which `mask_wr` loads.
- R13: `busy` stays high from acceptance until the answer is consumed and the status is updated. `rsp_byte_ready` is high only while bytes are being taken. Bytes beyond the sixteenth are consumed and dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_enable | input | 1 | Controller enable; commands are accepted only when high |
| cmd_wr | input | 1 | Command word write strobe |
| cmd_word | input | 16 | Command word |
| cmd_arg | input | ARG_W | Command argument |
| stat_clr_wr | input | 1 | Status write strobe |
| stat_clr_data | input | 16 | Status bits to clear (1 = clear) |
| mask_wr | input | 1 | Interrupt mask write strobe |
| mask_data | input | 15 | Interrupt mask value |
| card_req_valid | output | 1 | One-cycle card request |
| card_req_index | output | 6 | Request command index |
| card_req_arg | output | ARG_W | Request argument |
| rsp_cnt_valid | input | 1 | Answer byte count valid |
| rsp_cnt | input | CNT_W | Answer byte count |
| rsp_byte_valid | input | 1 | Answer byte valid |
| rsp_byte | input | 8 | Answer byte |
| rsp_byte_ready | output | 1 | Block accepts an answer byte |
| busy | output | 1 | Command in progress |
| rsp_words | output | 16*NUM_WORDS | Response words, word k at bits 16k+15:16k |
| status | output | 16 | Command status register |
| irq | output | 1 | Interrupt request |
| xfer_active | output | 1 | Data transfer armed |
| xfer_dir | output | 1 | Latched data direction |
| buf_rst | output | 1 | One-cycle data buffer reset |

## Verification
Most internal faults show up in `status` or `rsp_words` in the cycle after the last answer byte, when the single update step runs. A bad byte counter either finishes early, with a timeout bit and zero words, or leaves `busy` stuck high with the ready line still asserted. A faulty reversal of word order shows as swapped halves of `rsp_words` on the long answer. A bad decode shows one cycle after the write, in the request index, the transfer flags, or a missing request pulse.

// File: rtl/cmdcap_pkg.sv
package cmdcap_pkg;

   typedef enum logic [2:0] {
      RK_NONE,
      RK_R1,
      RK_R1B,
      RK_R2,
      RK_R3,
      RK_R6
   } rsp_kind_e;

   typedef struct packed {
      logic       dir;
      logic [1:0] cls;
      rsp_kind_e  kind;
      logic       init;
      logic [5:0] idx;
   } cmd_fields_t;

   localparam logic [1:0] CLS_ADDR_DATA = 2'd3;
   localparam logic [5:0] IDX_STOP      = 6'd12;

   localparam int SB_DONE  = 0;
   localparam int SB_STOP  = 2;
   localparam int SB_TMO   = 7;
   localparam int SB_CBUSY = 12;
   localparam int SB_RERR  = 14;

   function automatic int unsigned min_len(rsp_kind_e k);
      case (k)
         RK_NONE: min_len = 0;
         RK_R2:   min_len = 16;
         default: min_len = 4;
      endcase
   endfunction

endpackage

// File: rtl/cmdcap_decode.sv
module cmdcap_decode
   import cmdcap_pkg::*;
(
   input  logic [15:0] word,
   output cmd_fields_t fields
);
   logic [2:0] raw_kind;
   assign raw_kind = word[10:8];

   always_comb begin
      fields.idx  = word[5:0];
      fields.init = word[7];
      fields.cls  = word[13:12];
      fields.dir  = word[15];
      case (raw_kind)
         3'd1:    fields.kind = word[11] ? RK_R1B : RK_R1;
         3'd2:    fields.kind = RK_R2;
         3'd3:    fields.kind = RK_R3;
         3'd6:    fields.kind = RK_R6;
         default: fields.kind = RK_NONE;
      endcase
   end
endmodule

// File: rtl/cmdcap_rsp_buf.sv
module cmdcap_rsp_buf #(
   parameter int NUM_WORDS = 8,
   localparam int NUM_BYTES = 2 * NUM_WORDS,
   localparam int IDX_W     = $clog2(NUM_BYTES)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wipe,
   input  logic                   wr_en,
   input  logic [IDX_W-1:0]       wr_idx,
   input  logic [7:0]             wr_byte,
   input  logic                   commit,
   output logic [31:0]            head32,
   output logic [16*NUM_WORDS-1:0] words
);
   logic [7:0] byte_q [NUM_BYTES];

   for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            byte_q[b] <= '0;
         else if (wipe)
            byte_q[b] <= '0;
         else if (wr_en && wr_idx == IDX_W'(b))
            byte_q[b] <= wr_byte;
      end
   end

   for (genvar k = 0; k < NUM_WORDS; k++) begin : g_word
      localparam int HI = 2 * (NUM_WORDS - 1 - k);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            words[16*k +: 16] <= '0;
         else if (wipe)
            words[16*k +: 16] <= '0;
         else if (commit)
            words[16*k +: 16] <= {byte_q[HI], byte_q[HI+1]};
      end
   end

   assign head32 = {byte_q[0], byte_q[1], byte_q[2], byte_q[3]};
endmodule

// File: rtl/cmdcap_status.sv
module cmdcap_status (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [15:0] hw_set,
   input  logic [15:0] hw_clr,
   input  logic        sw_clr_wr,
   input  logic [15:0] sw_clr_data,
   input  logic        mask_wr,
   input  logic [14:0] mask_data,
   output logic [15:0] status,
   output logic        irq
);
   logic [14:0] mask_q;
   logic [15:0] sw_clr;

   assign sw_clr = sw_clr_wr ? sw_clr_data : 16'h0000;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status <= '0;
         mask_q <= '0;
      end else begin
         status <= (status & ~sw_clr & ~hw_clr) | hw_set;
         if (mask_wr)
            mask_q <= mask_data;
      end
   end

   assign irq = |(status[14:0] & mask_q);
endmodule

// File: rtl/cmd_resp_capture.sv
module cmd_resp_capture
   import cmdcap_pkg::*;
#(
   parameter int          ARG_W       = 32,
   parameter int          CNT_W       = 5,
   parameter int          NUM_WORDS   = 8,
   parameter logic [31:0] R1_ERR_MASK = 32'hFDF9_0000,
   parameter logic [15:0] R6_ERR_MASK = 16'hE008
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     ctl_enable,
   input  logic                     cmd_wr,
   input  logic [15:0]              cmd_word,
   input  logic [ARG_W-1:0]         cmd_arg,
   input  logic                     stat_clr_wr,
   input  logic [15:0]              stat_clr_data,
   input  logic                     mask_wr,
   input  logic [14:0]              mask_data,
   output logic                     card_req_valid,
   output logic [5:0]               card_req_index,
   output logic [ARG_W-1:0]         card_req_arg,
   input  logic                     rsp_cnt_valid,
   input  logic [CNT_W-1:0]         rsp_cnt,
   input  logic                     rsp_byte_valid,
   input  logic [7:0]               rsp_byte,
   output logic                     rsp_byte_ready,
   output logic                     busy,
   output logic [16*NUM_WORDS-1:0]  rsp_words,
   output logic [15:0]              status,
   output logic                     irq,
   output logic                     xfer_active,
   output logic                     xfer_dir,
   output logic                     buf_rst
);
   localparam int NUM_BYTES = 2 * NUM_WORDS;
   localparam int IDX_W     = $clog2(NUM_BYTES);
   localparam logic [CNT_W-1:0] BYTE_LIM = CNT_W'(NUM_BYTES);

   if (NUM_WORDS < 8) begin : g_chk_words
      $error("NUM_WORDS must hold a 16-byte answer");
   end
   if (CNT_W <= IDX_W) begin : g_chk_cnt
      $error("CNT_W too narrow for the answer length");
   end

   typedef enum logic [1:0] {ST_IDLE, ST_COUNT, ST_BYTES, ST_DONE} state_e;

   state_e         state_q;
   cmd_fields_t    dec;
   rsp_kind_e      kind_q;
   logic [5:0]     idx_q;
   logic [CNT_W-1:0] tot_q, rx_q, rx_nxt;
   logic           accept, init0, take, fill, tmo, err;
   logic [31:0]    head32;
   logic [15:0]    hw_set, hw_clr;

   cmdcap_decode u_dec (.word(cmd_word), .fields(dec));

   assign accept = cmd_wr && ctl_enable && (state_q == ST_IDLE);
   assign init0  = dec.init && (dec.idx == 6'd0);
   assign take   = (state_q == ST_BYTES) && rsp_byte_valid;
   assign rx_nxt = rx_q + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q        <= ST_IDLE;
         card_req_valid <= 1'b0;
         card_req_index <= '0;
         card_req_arg   <= '0;
         kind_q         <= RK_NONE;
         idx_q          <= '0;
         tot_q          <= '0;
         rx_q           <= '0;
         xfer_active    <= 1'b0;
         xfer_dir       <= 1'b0;
         buf_rst        <= 1'b0;
      end else begin
         card_req_valid <= 1'b0;
         buf_rst        <= 1'b0;
         case (state_q)
            ST_IDLE: if (accept && !init0) begin
               state_q        <= ST_COUNT;
               card_req_valid <= 1'b1;
               card_req_index <= dec.idx;
               card_req_arg   <= cmd_arg;
               kind_q         <= dec.kind;
               idx_q          <= dec.idx;
               if (dec.cls == CLS_ADDR_DATA) begin
                  xfer_active <= 1'b1;
                  xfer_dir    <= dec.dir;
                  buf_rst     <= 1'b1;
               end else begin
                  xfer_active <= 1'b0;
               end
            end
            ST_COUNT: if (rsp_cnt_valid) begin
               tot_q   <= rsp_cnt;
               rx_q    <= '0;
               state_q <= (rsp_cnt == '0) ? ST_DONE : ST_BYTES;
            end
            ST_BYTES: if (take) begin
               rx_q <= rx_nxt;
               if (rx_nxt == tot_q)
                  state_q <= ST_DONE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign rsp_byte_ready = (state_q == ST_BYTES);
   assign busy           = (state_q != ST_IDLE);

   cmdcap_rsp_buf #(.NUM_WORDS(NUM_WORDS)) u_buf (
      .clk(clk), .rst_n(rst_n), .wipe(accept),
      .wr_en(take && (rx_q < BYTE_LIM)), .wr_idx(rx_q[IDX_W-1:0]),
      .wr_byte(rsp_byte), .commit(fill), .head32(head32), .words(rsp_words)
   );

   always_comb begin
      tmo = int'(tot_q) < int'(min_len(kind_q));
      case (kind_q)
         RK_R1, RK_R1B: err = !tmo && |(head32 & R1_ERR_MASK);
         RK_R6:         err = !tmo && |(head32[15:0] & R6_ERR_MASK);
         default:       err = 1'b0;
      endcase
      fill   = (state_q == ST_DONE) && !tmo && (kind_q != RK_NONE);
      hw_set = '0;
      hw_clr = '0;
      if (accept && init0)
         hw_set[SB_DONE] = 1'b1;
      if (state_q == ST_DONE) begin
         hw_set[SB_RERR] = err;
         hw_clr[SB_RERR] = !err;
         if (tmo) begin
            hw_set[SB_TMO] = 1'b1;
         end else begin
            hw_set[SB_DONE]  = 1'b1;
            hw_set[SB_STOP]  = (idx_q == IDX_STOP);
            hw_set[SB_CBUSY] = (kind_q == RK_R3) && !head32[31];
         end
      end
   end

   cmdcap_status u_stat (
      .clk(clk), .rst_n(rst_n), .hw_set(hw_set), .hw_clr(hw_clr),
      .sw_clr_wr(stat_clr_wr), .sw_clr_data(stat_clr_data),
      .mask_wr(mask_wr), .mask_data(mask_data),
      .status(status), .irq(irq)
   );
endmodule

// File: rtl/cmd_resp_capture_chk.sv
module cmd_resp_capture_chk #(
   parameter int WORDS_W = 128
) (
   input logic               clk,
   input logic               rst_n,
   input logic               ctl_enable,
   input logic               cmd_wr,
   input logic               stat_clr_wr,
   input logic [15:0]        stat_clr_data,
   input logic               mask_wr,
   input logic [14:0]        mask_data,
   input logic               card_req_valid,
   input logic               rsp_byte_ready,
   input logic               busy,
   input logic [WORDS_W-1:0] rsp_words,
   input logic [15:0]        status,
   input logic               irq,
   input logic               xfer_active
);
   assert_req_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
      card_req_valid |=> !card_req_valid);

   assert_ignore_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && !ctl_enable && !busy) |=> (!busy && !card_req_valid));

   assert_wipe_words_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && ctl_enable && !busy) |=> (rsp_words == '0));

   assert_arm_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(xfer_active) |-> $past(cmd_wr && ctl_enable));

   assert_clear_all_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_clr_wr && (&stat_clr_data) && !busy && !cmd_wr) |=> (status == 16'h0000));

   assert_mask_off_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_wr && mask_data == 15'h0000) |=> !irq);

   assert_ready_busy_R13: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_byte_ready |-> busy);
endmodule

bind cmd_resp_capture cmd_resp_capture_chk chk_i (
   .clk(clk), .rst_n(rst_n), .ctl_enable(ctl_enable), .cmd_wr(cmd_wr),
   .stat_clr_wr(stat_clr_wr), .stat_clr_data(stat_clr_data),
   .mask_wr(mask_wr), .mask_data(mask_data),
   .card_req_valid(card_req_valid), .rsp_byte_ready(rsp_byte_ready),
   .busy(busy), .rsp_words(rsp_words), .status(status), .irq(irq),
   .xfer_active(xfer_active)
);

// File: tb/cmd_resp_capture_tb_top.sv
`timescale 1ns/1ps
module cmd_resp_capture_tb_top;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         ctl_enable = 1'b0;
   logic         cmd_wr = 1'b0;
   logic [15:0]  cmd_word = '0;
   logic [31:0]  cmd_arg = '0;
   logic         stat_clr_wr = 1'b0;
   logic [15:0]  stat_clr_data = '0;
   logic         mask_wr = 1'b0;
   logic [14:0]  mask_data = '0;
   logic         card_req_valid;
   logic [5:0]   card_req_index;
   logic [31:0]  card_req_arg;
   logic         rsp_cnt_valid = 1'b0;
   logic [4:0]   rsp_cnt = '0;
   logic         rsp_byte_valid = 1'b0;
   logic [7:0]   rsp_byte = '0;
   logic         rsp_byte_ready;
   logic         busy;
   logic [127:0] rsp_words;
   logic [15:0]  status;
   logic         irq;
   logic         xfer_active, xfer_dir, buf_rst;

   int n_chk = 0;
   int n_bad = 0;
   logic [7:0] ans [32];
   logic req_seen, pulse_seen;

   always #10 clk = ~clk;

   cmd_resp_capture dut_i (.*);

   task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] cw(logic [5:0] idx, logic init, logic [2:0] kind,
                                      logic bsy, logic [1:0] cls, logic dir);
      return {dir, 1'b0, cls, bsy, kind, init, 1'b0, idx};
   endfunction

   task automatic wr_status(logic [15:0] v);
      @(negedge clk); stat_clr_wr = 1'b1; stat_clr_data = v;
      @(negedge clk); stat_clr_wr = 1'b0;
   endtask

   task automatic wr_mask(logic [14:0] v);
      @(negedge clk); mask_wr = 1'b1; mask_data = v;
      @(negedge clk); mask_wr = 1'b0;
   endtask

   // nb < 0: no answer phase expected
   task automatic run_cmd(logic [15:0] w, logic [31:0] a, int nb);
      @(negedge clk); cmd_wr = 1'b1; cmd_word = w; cmd_arg = a;
      @(negedge clk); cmd_wr = 1'b0;
      req_seen   = card_req_valid;
      pulse_seen = buf_rst;
      if (nb >= 0) begin
         rsp_cnt_valid = 1'b1; rsp_cnt = 5'(nb);
         @(negedge clk); rsp_cnt_valid = 1'b0;
         for (int i = 0; i < nb; i++) begin
            for (int g = 0; g < 20 && !rsp_byte_ready; g++) @(negedge clk);
            rsp_byte_valid = 1'b1; rsp_byte = ans[i];
            @(negedge clk); rsp_byte_valid = 1'b0;
         end
      end
      for (int g = 0; g < 20 && busy; g++) @(negedge clk);
   endtask

   task automatic t_reset;
      chk("R12 reset status", 128'(status), 128'h0);
      chk("R12 reset irq", 128'(irq), 128'h0);
      chk("R13 reset busy", 128'(busy), 128'h0);
      chk("R8 reset words", rsp_words, 128'h0);
   endtask

   task automatic t_disabled;
      ctl_enable = 1'b0;
      run_cmd(cw(6'd17, 0, 3'd1, 0, 2'd2, 0), 32'h1, -1);
      chk("R2 disabled no request", 128'(req_seen), 128'h0);
      chk("R2 disabled status", 128'(status), 128'h0);
      chk("R2 disabled busy", 128'(busy), 128'h0);
      ctl_enable = 1'b1;
   endtask

   task automatic t_short_ok;
      ans[0] = 8'h00; ans[1] = 8'h00; ans[2] = 8'h09; ans[3] = 8'h00;
      run_cmd(cw(6'd17, 0, 3'd1, 0, 2'd2, 0), 32'hDEADBEEF, 4);
      chk("R1 request seen", 128'(req_seen), 128'h1);
      chk("R1 request index", 128'(card_req_index), 128'd17);
      chk("R1 request arg", 128'(card_req_arg), 128'hDEADBEEF);
      chk("R9 done only", 128'(status), 128'h0001);
      chk("R8 short words", rsp_words, {16'h0000, 16'h0900, 96'h0});
      wr_status(16'hFFFF);
      chk("R11 clear all", 128'(status), 128'h0);
   endtask

   task automatic t_err_irq;
      ans[0] = 8'h80; ans[1] = 8'h00; ans[2] = 8'h00; ans[3] = 8'h00;
      run_cmd(cw(6'd13, 0, 3'd1, 1, 2'd2, 0), 32'h0, 4);
      chk("R7 R1b error bit", 128'(status), 128'h4001);
      wr_mask(15'h4000);
      chk("R12 irq from error", 128'(irq), 128'h1);
      wr_mask(15'h0080);
      chk("R12 irq masked", 128'(irq), 128'h0);
      wr_status(16'h4000);
      chk("R11 partial clear", 128'(status), 128'h0001);
      wr_status(16'hFFFF);
   endtask

   task automatic t_timeouts;
      ans[0] = 8'h11; ans[1] = 8'h22; ans[2] = 8'h33;
      run_cmd(cw(6'd7, 0, 3'd1, 1, 2'd2, 0), 32'h0, 3);
      chk("R5 short R1b timeout", 128'(status), 128'h0080);
      chk("R5 short words zero", rsp_words, 128'h0);
      wr_status(16'hFFFF);
      for (int i = 0; i < 15; i++) ans[i] = 8'(i + 1);
      run_cmd(cw(6'd2, 0, 3'd2, 0, 2'd0, 0), 32'h0, 15);
      chk("R5 long timeout", 128'(status), 128'h0080);
      wr_status(16'hFFFF);
   endtask

   task automatic t_long;
      for (int i = 0; i < 20; i++) ans[i] = 8'(i + 1);
      run_cmd(cw(6'd2, 0, 3'd2, 0, 2'd0, 0), 32'h0, 20);
      chk("R8 long reversed", rsp_words, 128'h0102030405060708090A0B0C0D0E0F10);
      chk("R13 extra bytes drained", 128'(busy), 128'h0);
      chk("R9 long done", 128'(status), 128'h0001);
      wr_status(16'hFFFF);
      run_cmd(cw(6'd0, 1, 3'd0, 0, 2'd0, 0), 32'h0, -1);
      chk("R4 no request", 128'(req_seen), 128'h0);
      chk("R4 done only", 128'(status), 128'h0001);
      chk("R3 words wiped", rsp_words, 128'h0);
      wr_status(16'hFFFF);
   endtask

   task automatic t_ocr;
      ans[0] = 8'h00; ans[1] = 8'hFF; ans[2] = 8'h80; ans[3] = 8'h00;
      run_cmd(cw(6'd41, 0, 3'd3, 0, 2'd1, 0), 32'h0, 4);
      chk("R6 card busy", 128'(status), 128'h1001);
      wr_status(16'hFFFF);
      ans[0] = 8'h80;
      run_cmd(cw(6'd41, 0, 3'd3, 0, 2'd1, 0), 32'h0, 4);
      chk("R6 card ready", 128'(status), 128'h0001);
      wr_status(16'hFFFF);
   endtask

   task automatic t_r6_stop;
      ans[0] = 8'h12; ans[1] = 8'h34; ans[2] = 8'h20; ans[3] = 8'h00;
      run_cmd(cw(6'd3, 0, 3'd6, 0, 2'd1, 0), 32'h0, 4);
      chk("R7 R6 error", 128'(status), 128'h4001);
      ans[2] = 8'h01;
      run_cmd(cw(6'd3, 0, 3'd6, 0, 2'd1, 0), 32'h0, 4);
      chk("R7 R6 error cleared", 128'(status), 128'h0001);
      wr_status(16'hFFFF);
      ans[0] = 8'h00; ans[1] = 8'h00; ans[2] = 8'h00;
      run_cmd(cw(6'd12, 0, 3'd1, 0, 2'd2, 0), 32'h0, 4);
      chk("R9 stop bits", 128'(status), 128'h0005);
      wr_status(16'hFFFF);
   endtask

   task automatic t_xfer_busy;
      ans[0] = 8'h00; ans[1] = 8'h00; ans[2] = 8'h00; ans[3] = 8'h00;
      run_cmd(cw(6'd18, 0, 3'd1, 0, 2'd3, 1), 32'h0, 4);
      chk("R10 buffer reset pulse", 128'(pulse_seen), 128'h1);
      chk("R10 active", 128'(xfer_active), 128'h1);
      chk("R10 direction", 128'(xfer_dir), 128'h1);
      // a second write while busy must not issue a request
      @(negedge clk); cmd_wr = 1'b1; cmd_word = cw(6'd9, 0, 3'd0, 0, 2'd0, 0);
      @(negedge clk); cmd_wr = 1'b0;
      chk("R1 first request", 128'(card_req_index), 128'd9);
      cmd_wr = 1'b1; cmd_word = cw(6'd5, 0, 3'd0, 0, 2'd0, 0);
      @(negedge clk); cmd_wr = 1'b0;
      chk("R2 busy ignore", 128'(card_req_valid), 128'h0);
      chk("R10 cleared", 128'(xfer_active), 128'h0);
      chk("R13 busy held", 128'(busy), 128'h1);
      rsp_cnt_valid = 1'b1; rsp_cnt = 5'd0;
      @(negedge clk); rsp_cnt_valid = 1'b0;
      @(negedge clk);
      chk("R13 index kept", 128'(card_req_index), 128'd9);
      chk("R13 idle", 128'(busy), 128'h0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_disabled();
      t_short_ok();
      t_err_irq();
      t_timeouts();
      t_long();
      t_ocr();
      t_r6_stop();
      t_xfer_busy();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule